// File: doc/BRIEF.md
# Element-write row-read matrix memory

This block is an on-chip store for a square matrix of fixed-point elements, 17 by 17 at 56 bits each by default. The two ports have different widths. A producer fills the matrix one element at a time, naming the row and the column. A consumer asks for a whole row and gets all 17 elements side by side in a single wide word.

To make a full row available in one access, the storage is cut into one bank per column, and each bank is as deep as the matrix has rows. A write enables only the bank its column picks. A read presents the same row index to every bank at once. Read data comes out one clock after the request, together with a valid strobe. Out-of-range indices are refused: the contents stay as they were, and a flag pulses in the following cycle.

Reset is asynchronous and active-low, and its release is synchronised inside the block, so requests are accepted from the third rising edge after `rst_n` goes high.

Top module: `rowmat_store`

## Requirements
- R1: While reset is held, and until requests are accepted, `rd_valid`, `rd_reject` and `wr_reject` are low and `rd_data` is all zeros.
- R2: When `wr_en` is high and both `wr_row` and `wr_col` are below 17, `wr_data` is stored into that one element, and every other element keeps its value.
- R3: When `rd_en` is high and `rd_row` is below 17, `rd_valid` is high in the next cycle and `rd_data` holds that row. The element of column c sits at bits [c*56+55 : c*56].
- R4: A read of a row in the same cycle as a write into that row returns the value from before the write. A later read returns the new value.
- R5: A write whose row or column is 17 or more changes no element, and `wr_reject` is high in the next cycle. It is low after every other cycle.
- R6: A read whose row is 17 or more gives `rd_valid` low and `rd_reject` high in the next cycle, and `rd_data` stays unchanged. `rd_reject` is low after every other cycle.
- R7: After a cycle with no accepted read, `rd_valid` is low and `rd_data` keeps its previous value.
- R8: Reads issued on consecutive cycles return one row per cycle, in request order.
- R9: A write and a read to different rows in the same cycle do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Element write request |
| wr_row | input | 5 | Row index of the element written |
| wr_col | input | 5 | Column index of the element written |
| wr_data | input | 56 | Element value |
| rd_en | input | 1 | Row read request |
| rd_row | input | 5 | Row index to read |
| rd_data | output | 952 | Row contents; column c at bits [c*56 +: 56] |
| rd_valid | output | 1 | `rd_data` carries a row read in the previous cycle |
| rd_reject | output | 1 | The previous cycle's read had an out-of-range row |
| wr_reject | output | 1 | The previous cycle's write had an out-of-range index |

## Verification
The hardest case to reach is a read and a write that land on the same row in the same cycle, because the returned word must mix the unchanged columns with the old value of the column being written. The stimulus first fills every element with a value that encodes its row and column. It then issues same-row read/write pairs on several columns, each followed at once by a plain read of that row. It also uses rejected indices, including ones whose low bits would alias a real row or column, and then reads every row back, so that any stray change to the storage shows up at the read port.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  localparam int unsigned MRM_DIM    = 17;
  localparam int unsigned MRM_ELEM_W = 56;
endpackage

// File: rtl/mrm_rst_sync.sv
module mrm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/mrm_req_decode.sv
module mrm_req_decode #(
  parameter int unsigned DIM   = 17,
  parameter int unsigned IDX_W = 5
) (
  input  logic             req_ok,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_row,
  input  logic [IDX_W-1:0] wr_col,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_row,
  output logic             wr_go,
  output logic             wr_bad,
  output logic             rd_go,
  output logic             rd_bad,
  output logic [DIM-1:0]   bank_we
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DIM);

  logic wr_in_range;
  logic rd_in_range;

  always_comb begin
    wr_in_range = (wr_row < LIMIT) && (wr_col < LIMIT);
    rd_in_range = (rd_row < LIMIT);
    wr_go  = req_ok && wr_en && wr_in_range;
    wr_bad = req_ok && wr_en && !wr_in_range;
    rd_go  = req_ok && rd_en && rd_in_range;
    rd_bad = req_ok && rd_en && !rd_in_range;
  end

  for (genvar c = 0; c < DIM; c++) begin : g_we
    assign bank_we[c] = wr_go && (wr_col == IDX_W'(c));
  end
endmodule

// File: rtl/mrm_col_bank.sv
module mrm_col_bank #(
  parameter int unsigned DEPTH = 17,
  parameter int unsigned WIDTH = 56,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;
  logic [WIDTH-1:0] rdata_d;

  // Storage array: no reset, write on enable only.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Next-state for the output register; the old array value is taken,
  // so a same-address write in this cycle is not yet visible.
  always_comb begin
    rdata_d = rdata_q;
    if (re) begin
      rdata_d = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rowmat_store.sv
module rowmat_store
  import mrm_pkg::*;
#(
  parameter int unsigned DIM    = MRM_DIM,
  parameter int unsigned ELEM_W = MRM_ELEM_W,
  parameter int unsigned IDX_W  = $clog2(DIM + 1),
  parameter int unsigned ROW_W  = DIM * ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [IDX_W-1:0]  wr_col,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_row,
  output logic [ROW_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              rd_reject,
  output logic              wr_reject
);
  logic           rst_sync_n;
  logic           wr_go;
  logic           wr_bad;
  logic           rd_go;
  logic           rd_bad;
  logic [DIM-1:0] bank_we;

  logic rd_valid_q, rd_valid_d;
  logic rd_reject_q, rd_reject_d;
  logic wr_reject_q, wr_reject_d;

  mrm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mrm_req_decode #(
    .DIM   (DIM),
    .IDX_W (IDX_W)
  ) u_decode (
    .req_ok  (rst_sync_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .rd_en   (rd_en),
    .rd_row  (rd_row),
    .wr_go   (wr_go),
    .wr_bad  (wr_bad),
    .rd_go   (rd_go),
    .rd_bad  (rd_bad),
    .bank_we (bank_we)
  );

  for (genvar c = 0; c < DIM; c++) begin : g_bank
    mrm_col_bank #(
      .DEPTH (DIM),
      .WIDTH (ELEM_W),
      .AW    (IDX_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (bank_we[c]),
      .waddr (wr_row),
      .wdata (wr_data),
      .re    (rd_go),
      .raddr (rd_row),
      .rdata (rd_data[c*ELEM_W +: ELEM_W])
    );
  end

  always_comb begin
    rd_valid_d  = rd_go;
    rd_reject_d = rd_bad;
    wr_reject_d = wr_bad;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_q  <= 1'b0;
      rd_reject_q <= 1'b0;
      wr_reject_q <= 1'b0;
    end else begin
      rd_valid_q  <= rd_valid_d;
      rd_reject_q <= rd_reject_d;
      wr_reject_q <= wr_reject_d;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_reject = rd_reject_q;
  assign wr_reject = wr_reject_q;
endmodule

// File: rtl/mrm_checker.sv
module mrm_checker #(
  parameter int unsigned DIM    = 17,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned ROW_W  = 952
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_row,
  input logic [IDX_W-1:0] wr_col,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_row,
  input logic [ROW_W-1:0] rd_data,
  input logic             rd_valid,
  input logic             rd_reject,
  input logic             wr_reject
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DIM);

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && rd_row < LIMIT) |=> (rd_valid && !rd_reject)); // R3

  AST_RD_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && rd_row >= LIMIT) |=> (rd_reject && !rd_valid && $stable(rd_data))); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_en && rd_row < LIMIT) |=> !rd_valid); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_en && rd_row < LIMIT) |=> $stable(rd_data)); // R7

  AST_WR_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && (wr_row >= LIMIT || wr_col >= LIMIT)) |=> wr_reject); // R5

  AST_WR_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_ok)
    !(wr_en && (wr_row >= LIMIT || wr_col >= LIMIT)) |=> !wr_reject); // R5

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_valid && rd_reject)); // R6

  always_comb begin
    if (!rst_ok) begin
      AST_RESET_QUIET: assert (!rd_valid && !rd_reject && !wr_reject); // R1
    end
  end
endmodule

bind rowmat_store mrm_checker #(
  .DIM   (DIM),
  .IDX_W (IDX_W),
  .ROW_W (ROW_W)
) u_checker (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .wr_en     (wr_en),
  .wr_row    (wr_row),
  .wr_col    (wr_col),
  .rd_en     (rd_en),
  .rd_row    (rd_row),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rd_reject (rd_reject),
  .wr_reject (wr_reject)
);

// File: tb/rowmat_store_test.sv
`timescale 1ns/1ps
module rowmat_store_test;
  localparam int N  = 17;
  localparam int EW = 56;
  localparam int IW = 5;
  localparam int RW = N * EW;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_row;
  logic [IW-1:0] wr_col;
  logic [EW-1:0] wr_data;
  logic          rd_en;
  logic [IW-1:0] rd_row;
  logic [RW-1:0] rd_data;
  logic          rd_valid;
  logic          rd_reject;
  logic          wr_reject;

  rowmat_store uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_row    (rd_row),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_reject (rd_reject),
    .wr_reject (wr_reject)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic          v;
    logic          rrej;
    logic          wrej;
    logic [RW-1:0] d;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [EW-1:0] model [N][N];
  logic [RW-1:0] last_row;
  int            n_cmp;
  int            n_bad;
  logic          finished;

  function automatic logic [EW-1:0] pat(int r, int c, int salt);
    return {8'(r), 8'(c), 8'(salt), (32'(r * 31 + c * 7 + salt) ^ 32'hC3A5_9E17)};
  endfunction

  // Driver: drives one cycle of requests and queues the expected outcome.
  task automatic step(input logic we, input int wr, input int wc, input logic [EW-1:0] wd,
                      input logic re, input int rr, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en   = we;
    wr_row  = IW'(wr);
    wr_col  = IW'(wc);
    wr_data = wd;
    rd_en   = re;
    rd_row  = IW'(rr);
    it.v    = re && (rr < N);
    it.rrej = re && (rr >= N);
    it.wrej = we && ((wr >= N) || (wc >= N));
    if (it.v) begin
      for (int c = 0; c < N; c++) last_row[c*EW +: EW] = model[rr][c];
    end
    it.d   = last_row;
    it.tag = tag;
    if (we && wr < N && wc < N) model[wr][wc] = wd;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, '0, 1'b0, 0, tag);
  endtask

  // Monitor: compares outputs a little after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (rd_valid !== it.v || rd_reject !== it.rrej || wr_reject !== it.wrej ||
            rd_data !== it.d) begin
          n_bad++;
          $display("FAIL %s: valid/rrej/wrej=%b%b%b expected %b%b%b data=%h expected %h",
                   it.tag, rd_valid, rd_reject, wr_reject, it.v, it.rrej, it.wrej,
                   rd_data, it.d);
        end
      end
    end
  end

  initial begin
    finished = 1'b0;
    #(20 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    last_row = '0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_row = '0; wr_col = '0; wr_data = '0;
    rd_en = 1'b0; rd_row = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    n_cmp++;
    if (rd_valid !== 1'b0 || rd_reject !== 1'b0 || wr_reject !== 1'b0 || rd_data !== '0) begin
      n_bad++;
      $display("FAIL R1: valid/rrej/wrej=%b%b%b expected 000 data=%h expected 0",
               rd_valid, rd_reject, wr_reject, rd_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: fill every element
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        step(1'b1, r, c, pat(r, c, 1), 1'b0, 0, "R2 fill");
    idle(2, "R7 idle after fill");

    // R3 / R8: back-to-back reads of every row
    for (int r = 0; r < N; r++) step(1'b0, 0, 0, '0, 1'b1, r, "R3 R8 row read");
    idle(3, "R7 hold");

    // R4: same-row read and write, then read again
    step(1'b1, 4, 9, pat(4, 9, 2), 1'b1, 4, "R4 read-before-write");
    step(1'b0, 0, 0, '0, 1'b1, 4, "R4 new value");
    step(1'b1, 16, 16, pat(16, 16, 3), 1'b1, 16, "R4 last element");
    step(1'b0, 0, 0, '0, 1'b1, 16, "R4 last element new");
    step(1'b1, 0, 0, pat(0, 0, 4), 1'b1, 0, "R4 first element");
    step(1'b1, 0, 1, pat(0, 1, 4), 1'b1, 0, "R4 second write same row");
    step(1'b0, 0, 0, '0, 1'b1, 0, "R4 both visible");

    // R5: rejected writes, including aliasing indices
    step(1'b1, 17, 5, pat(9, 9, 9), 1'b0, 0, "R5 row 17");
    step(1'b1, 3, 17, pat(9, 9, 9), 1'b0, 0, "R5 col 17");
    step(1'b1, 31, 31, pat(9, 9, 9), 1'b0, 0, "R5 row/col 31");
    step(1'b1, 1, 25, pat(9, 9, 9), 1'b1, 1, "R5 col 25 with read");
    idle(1, "R5 flag clears");
    for (int r = 0; r < N; r++) step(1'b0, 0, 0, '0, 1'b1, r, "R5 contents unchanged");

    // R6: rejected reads leave data held
    step(1'b0, 0, 0, '0, 1'b1, 17, "R6 row 17");
    step(1'b0, 0, 0, '0, 1'b1, 31, "R6 row 31");
    step(1'b0, 0, 0, '0, 1'b1, 2, "R6 good after bad");
    step(1'b0, 0, 0, '0, 1'b1, 20, "R6 row 20");
    idle(2, "R7 hold after reject");

    // R9: write and read different rows together
    for (int i = 0; i < N; i++)
      step(1'b1, (i + 5) % N, i, pat(i, i, 7), 1'b1, i, "R9 cross rows");
    for (int r = 0; r < N; r++) step(1'b0, 0, 0, '0, 1'b1, r, "R9 readback");
    idle(4, "R7 drain");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule